// File: doc/BRIEF.md
# Programmable Access Wait-State Generator

This block sits on the processor side of the memory bus and decides how long every access is stalled. The 32-bit address space is cut into sixteen timing regions. Most regions have fixed costs. Three cartridge ROM windows take their costs from a 16-bit wait-control register, which software rewrites through a simple write strobe.

For each request the block reads the region from the address, the access width (16 or 32 bits) and whether the access continues a sequential burst. It works out the total cycle count, holds the bus stalled, and returns a one-cycle ready pulse exactly that many cycles after it accepts the request. The ROM window costs live in a small table of registers. That table is rebuilt from the write data whenever the control register is written, and from an all-zero control word at reset.

Top module: `mem_wait_gen`

## Requirements
- R1: The timing region is address bits 27:24. All other address bits, including 31:28, have no effect on the cost.
- R2: Fixed-region costs, as 16-bit/32-bit cycles, apply to both sequential and non-sequential accesses: region 2 costs 3/6; regions 5, 6 and 7 cost 1/2; regions 0, 1, 3, 4, 14 and 15 cost 1/1.
- R3: ROM windows are regions 8–9 (window 0), 10–11 (window 1) and 12–13 (window 2). A non-sequential 16-bit access costs 1 plus a wait taken from a 2-bit code. The code sits at control bits 3:2, 6:5 and 9:8 for windows 0, 1 and 2. Codes 0, 1, 2 and 3 give waits of 4, 3, 2 and 8.
- R4: A sequential 16-bit ROM access costs 1 plus a wait chosen by one control bit: bit 4, 7 or 10 for windows 0, 1 or 2. When that bit is 1 the wait is 1. When it is 0 the wait is 2, 4 or 8 for windows 0, 1 or 2.
- R5: A sequential 32-bit ROM access costs twice the sequential 16-bit cost of its window.
- R6: A non-sequential 32-bit ROM access costs 1 plus the non-sequential 16-bit cost plus the sequential 16-bit cost of its window.
- R7: Reset leaves the block idle, with the ready pulse and the stall low, and the ROM costs equal to those of an all-zero control word.
- R8: A request is accepted on a rising edge where the block is idle and the valid input is high. The ready pulse is one cycle wide and is sampled high at the N-th rising edge after acceptance, where N is the cost. The stall is high from the valid request until the ready cycle, and low in the ready cycle and whenever no request is pending.
- R9: A request still valid after a ready pulse is accepted on the edge that follows the cycle after ready. Back-to-back requests therefore complete N+1 cycles after the previous ready.
- R10: A control write changes the costs only of requests accepted after the write edge. A request accepted on the same edge as a write, or already running when the write occurs, keeps its earlier cost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Writes cfgWrData into the wait-control register |
| cfgWrData | input | 16 | New wait-control word |
| reqValid | input | 1 | Access request, held until ready |
| reqAddr | input | 32 | Access address |
| reqWide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| reqSeq | input | 1 | 1 = sequential, 0 = non-sequential |
| reqReady | output | 1 | One-cycle completion pulse |
| busStall | output | 1 | Bus is held waiting |

## Verification
A control-register write and a request acceptance can land on the same clock edge. The bench raises the write strobe and the valid input together before one edge and expects the old cost on that access, then the new cost on the next access. A second case writes while a long ROM access is counting down. The completion must still arrive on the old count, which shows the running counter ignores the new table. A scoreboard measures every latency from the observed acceptance edge, so a late, early or doubled ready pulse shows up in the same comparison.

// File: rtl/wsg_pkg.sv
`timescale 1ns/1ps
package wsg_pkg;
  localparam int CNT_W     = 5;
  localparam int CFG_W     = 16;
  localparam int NUM_WIN   = 3;
  localparam int REG_W     = 4;
  localparam int ROM_FIRST = 8;
  localparam int WIN_STEP  = 3;
  localparam int NS_LSB    = 2;
  localparam int SQ_BIT    = 4;

  typedef logic [CNT_W-1:0] cyc_t;

  typedef struct packed {
    cyc_t n16;
    cyc_t s16;
    cyc_t n32;
    cyc_t s32;
  } winCost_t;

  typedef struct packed {
    logic acceptReq;
    logic tickCnt;
    logic loadCfg;
  } strobes_t;

  function automatic cyc_t nsWait(logic [1:0] code);
    case (code)
      2'd0:    return cyc_t'(4);
      2'd1:    return cyc_t'(3);
      2'd2:    return cyc_t'(2);
      default: return cyc_t'(8);
    endcase
  endfunction

  function automatic cyc_t seqWait(logic fast, int win);
    if (fast) return cyc_t'(1);
    return cyc_t'(2 << win);
  endfunction

  function automatic winCost_t calcWin(logic [CFG_W-1:0] cfg, int win);
    winCost_t c;
    logic [1:0] code;
    logic fast;
    code  = cfg[NS_LSB + WIN_STEP*win +: 2];
    fast  = cfg[SQ_BIT + WIN_STEP*win];
    c.n16 = cyc_t'(1) + nsWait(code);
    c.s16 = cyc_t'(1) + seqWait(fast, win);
    c.s32 = c.s16 + c.s16;
    c.n32 = cyc_t'(1) + c.n16 + c.s16;
    return c;
  endfunction

  function automatic cyc_t fixedCost(logic [REG_W-1:0] region, logic wide);
    case (region)
      4'h2:             return wide ? cyc_t'(6) : cyc_t'(3);
      4'h5, 4'h6, 4'h7: return wide ? cyc_t'(2) : cyc_t'(1);
      default:          return cyc_t'(1);
    endcase
  endfunction
endpackage

// File: rtl/wsg_cost.sv
`timescale 1ns/1ps
module wsg_cost
  import wsg_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int REGION_LSB = 24
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          wide,
  input  logic                          seq,
  input  winCost_t [NUM_WIN-1:0]        costTab,
  output cyc_t                          cost
);
  localparam int ROM_LAST = ROM_FIRST + 2*NUM_WIN - 1;
  localparam int IDX_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  logic [REG_W-1:0] region;
  logic [REG_W-1:0] romOff;
  logic             romHit;
  logic [IDX_W-1:0] winIdx;
  winCost_t         winSel;

  always_comb begin
    region = addr[REGION_LSB +: REG_W];
    romOff = region - REG_W'(ROM_FIRST);
    romHit = (int'(region) >= ROM_FIRST) && (int'(region) <= ROM_LAST);
    winIdx = IDX_W'(romOff >> 1);
    winSel = costTab[winIdx];
    if (romHit) begin
      case ({wide, seq})
        2'b00:   cost = winSel.n16;
        2'b01:   cost = winSel.s16;
        2'b10:   cost = winSel.n32;
        default: cost = winSel.s32;
      endcase
    end else begin
      cost = fixedCost(region, wide);
    end
  end
endmodule

// File: rtl/wsg_datapath.sv
`timescale 1ns/1ps
module wsg_datapath
  import wsg_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int REGION_LSB = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobes_t          stb,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWide,
  input  logic              reqSeq,
  output logic              lastTick
);
  winCost_t [NUM_WIN-1:0] costTab;
  cyc_t                   reqCost;
  cyc_t                   cnt;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           costTab[w] <= calcWin('0, w);
      else if (stb.loadCfg) costTab[w] <= calcWin(cfgWrData, w);
    end

    a_r5_seq32_double: assert property (@(posedge clk) disable iff (!rst_n)
      costTab[w].s32 == costTab[w].s16 + costTab[w].s16);
    a_r6_nseq32_split: assert property (@(posedge clk) disable iff (!rst_n)
      costTab[w].n32 == cyc_t'(1) + costTab[w].n16 + costTab[w].s16);
  end

  wsg_cost #(.ADDR_W(ADDR_W), .REGION_LSB(REGION_LSB)) u_cost (
    .addr    (reqAddr),
    .wide    (reqWide),
    .seq     (reqSeq),
    .costTab (costTab),
    .cost    (reqCost)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (stb.acceptReq) cnt <= reqCost;
    else if (stb.tickCnt)   cnt <= cnt - cyc_t'(1);
  end

  assign lastTick = (cnt == cyc_t'(1));

  a_r8_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    stb.tickCnt |-> cnt > cyc_t'(1));
  a_r2_ext_ram_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (reqAddr[REGION_LSB +: REG_W] == 4'h2 && reqWide) |-> reqCost == cyc_t'(6));
  a_r10_write_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.loadCfg && stb.tickCnt) |=> cnt == $past(cnt) - cyc_t'(1));
endmodule

// File: rtl/wsg_ctrl.sv
`timescale 1ns/1ps
module wsg_ctrl
  import wsg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     reqValid,
  input  logic     cfgWrEn,
  input  logic     lastTick,
  output strobes_t stb,
  output logic     reqReady,
  output logic     busStall
);
  typedef enum logic {ST_IDLE, ST_WAIT} state_t;
  state_t state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           state <= ST_IDLE;
    else if (state == ST_IDLE && reqValid) state <= ST_WAIT;
    else if (state == ST_WAIT && lastTick) state <= ST_IDLE;
  end

  always_comb begin
    stb.acceptReq = (state == ST_IDLE) && reqValid;
    stb.tickCnt   = (state == ST_WAIT) && !lastTick;
    stb.loadCfg   = cfgWrEn;
    reqReady      = (state == ST_WAIT) && lastTick;
    busStall      = stb.acceptReq || stb.tickCnt;
  end

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |=> !reqReady);
  a_r9_reopen_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |=> state == ST_IDLE);
  a_r8_stall_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && !reqReady) |-> busStall);
  a_r8_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(reqReady && busStall));
endmodule

// File: rtl/mem_wait_gen.sv
`timescale 1ns/1ps
module mem_wait_gen
  import wsg_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int REGION_LSB = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWide,
  input  logic              reqSeq,
  output logic              reqReady,
  output logic              busStall
);
  strobes_t stb;
  logic     lastTick;

  wsg_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .cfgWrEn  (cfgWrEn),
    .lastTick (lastTick),
    .stb      (stb),
    .reqReady (reqReady),
    .busStall (busStall)
  );

  wsg_datapath #(.ADDR_W(ADDR_W), .REGION_LSB(REGION_LSB)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .cfgWrData (cfgWrData),
    .reqAddr   (reqAddr),
    .reqWide   (reqWide),
    .reqSeq    (reqSeq),
    .lastTick  (lastTick)
  );
endmodule

// File: tb/mem_wait_gen_test.sv
`timescale 1ns/1ps
module mem_wait_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [15:0] cfgWrData = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqWide = 1'b0;
  logic        reqSeq = 1'b0;
  logic        reqReady;
  logic        busStall;

  int          errors = 0;
  int          checks = 0;
  int          expQ[$];
  string       tagQ[$];
  logic [15:0] cfgModel = '0;

  always #2.5 clk = ~clk;

  mem_wait_gen uut (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqWide(reqWide), .reqSeq(reqSeq),
    .reqReady(reqReady), .busStall(busStall)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected cost from the requirement text (R1..R6)
  function automatic int model(logic [15:0] cfg, logic [31:0] a, bit wide, bit seq);
    int r, w, nsw, n16, s16;
    r = int'(a[27:24]);
    if (r >= 8 && r <= 13) begin
      w = (r - 8) / 2;
      case (cfg[2 + 3*w +: 2])
        2'd0: nsw = 4;
        2'd1: nsw = 3;
        2'd2: nsw = 2;
        default: nsw = 8;
      endcase
      n16 = 1 + nsw;
      s16 = cfg[4 + 3*w] ? 2 : 1 + (2 << w);
      if (!wide) return seq ? s16 : n16;
      return seq ? 2 * s16 : 1 + n16 + s16;
    end
    if (r == 2) return wide ? 6 : 3;
    if (r >= 5 && r <= 7) return wide ? 2 : 1;
    return 1;
  endfunction

  function automatic string romTag(bit wide, bit seq);
    if (wide) return seq ? "R5" : "R6";
    return seq ? "R4" : "R3";
  endfunction

  // Scoreboard monitor: finds the acceptance edge, measures latency to ready
  initial begin
    bit busyM;
    bit armed;
    int cnt;
    int e;
    string t;
    busyM = 0; armed = 1; cnt = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        busyM = 0; armed = 1;
      end else begin
        if (!busyM) begin
          if (armed && reqValid) begin busyM = 1; cnt = 0; end
          else armed = 1;
        end
        if (busyM) begin
          cnt++;
          if (reqReady) begin
            if (expQ.size() == 0) chk(0, "R8 unexpected ready", cnt, 0);
            else begin
              e = expQ.pop_front(); t = tagQ.pop_front();
              chk(cnt == e, {t, " latency"}, cnt, e);
            end
            chk(!busStall, "R8 stall low in ready cycle", int'(busStall), 0);
            busyM = 0; armed = 0;
          end else begin
            chk(busStall, "R8 stall high while waiting", int'(busStall), 1);
            if (cnt > 64) begin
              chk(0, "R8 ready missing", cnt, 0);
              busyM = 0;
            end
          end
        end
      end
    end
  end

  task automatic writeCfg(logic [15:0] d);
    @(negedge clk); #1;
    cfgWrEn = 1'b1; cfgWrData = d;
    @(negedge clk); #1;
    cfgWrEn = 1'b0;
    cfgModel = d;
  endtask

  task automatic doReq(logic [31:0] a, bit wide, bit seq, int expN, string tag,
                       bit b2b, bit wrSame, bit wrMid, logic [15:0] wrData);
    int cycles;
    bit rdy;
    expQ.push_back(expN); tagQ.push_back(tag);
    if (!b2b) @(negedge clk);
    #1;
    reqAddr = a; reqWide = wide; reqSeq = seq; reqValid = 1'b1;
    if (wrSame) begin cfgWrEn = 1'b1; cfgWrData = wrData; end
    cycles = 0;
    forever begin
      @(negedge clk);
      cycles++;
      rdy = reqReady;
      if (rdy || cycles > 64) break;
      if (wrSame && cycles == 1) begin #1; cfgWrEn = 1'b0; end
      if (wrMid && cycles == 2) begin #1; cfgWrEn = 1'b1; cfgWrData = wrData; end
      if (wrMid && cycles == 3) begin #1; cfgWrEn = 1'b0; end
    end
    if (b2b) chk(rdy && cycles == expN + 1, {"R9 back-to-back ", tag}, cycles, expN + 1);
    else     chk(rdy && cycles == expN, {"R8 driver ", tag}, cycles, expN);
  endtask

  task automatic endReq();
    #1; reqValid = 1'b0;
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R8 watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] a;
    logic [15:0] cfgList[4];
    logic [15:0] oldCfg;
    int fixedReg[10];
    cfgList = '{16'h0754, 16'h07FC, 16'h04A8, 16'h0324};
    fixedReg = '{0, 1, 2, 3, 4, 5, 6, 7, 14, 15};

    repeat (3) @(negedge clk);
    chk(reqReady == 1'b0, "R7 ready low in reset", int'(reqReady), 0);
    chk(busStall == 1'b0, "R7 stall low in reset", int'(busStall), 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b0, "R7 ready low after reset", int'(reqReady), 0);
    chk(busStall == 1'b0, "R7 stall low after reset", int'(busStall), 0);

    // R7: reset timing table equals an all-zero control word
    doReq(32'h0800_0000, 0, 0, 5,  "R7 window0 n16", 0, 0, 0, '0);
    doReq(32'h0D00_0000, 1, 1, 18, "R7 window2 s32", 0, 0, 0, '0);
    endReq();

    // R2: fixed regions, both widths and both access kinds
    foreach (fixedReg[i]) begin
      for (int wd = 0; wd < 2; wd++) begin
        for (int sq = 0; sq < 2; sq++) begin
          a = {4'h0, 4'(fixedReg[i]), 24'h00AB_CD};
          doReq(a, wd[0], sq[0], model(cfgModel, a, wd[0], sq[0]), "R2", 0, 0, 0, '0);
        end
      end
    end

    // R1: upper and lower address bits have no effect
    doReq(32'hA2FF_FFFF, 1, 0, 6,  "R1 region2 upper bits", 0, 0, 0, '0);
    doReq(32'h7DFE_DCBA, 0, 0, 5,  "R1 region13 upper bits", 0, 0, 0, '0);
    doReq(32'hF500_0001, 1, 1, 2,  "R1 region5 upper bits", 0, 0, 0, '0);
    endReq();

    // R3..R6 across control words
    for (int c = -1; c < 4; c++) begin
      if (c >= 0) writeCfg(cfgList[c]);
      for (int r = 8; r <= 13; r++) begin
        for (int wd = 0; wd < 2; wd++) begin
          for (int sq = 0; sq < 2; sq++) begin
            a = {4'h0, 4'(r), 24'h12_3456};
            doReq(a, wd[0], sq[0], model(cfgModel, a, wd[0], sq[0]),
                  romTag(wd[0], sq[0]), 0, 0, 0, '0);
          end
        end
      end
      endReq();
    end

    // R9: back-to-back requests
    doReq(32'h0C00_0000, 0, 0, model(cfgModel, 32'h0C00_0000, 0, 0), "R9 first", 0, 0, 0, '0);
    doReq(32'h0300_0000, 0, 0, 1, "R9 second", 1, 0, 0, '0);
    doReq(32'h0200_0000, 1, 0, 6, "R9 third", 1, 0, 0, '0);
    doReq(32'h0A00_0000, 1, 1, model(cfgModel, 32'h0A00_0000, 1, 1), "R9 fourth", 1, 0, 0, '0);
    endReq();

    // R10: write on the acceptance edge keeps the old cost
    writeCfg(16'h0000);
    oldCfg = cfgModel;
    doReq(32'h0C00_0000, 1, 0, model(oldCfg, 32'h0C00_0000, 1, 0),
          "R10 same-edge write", 0, 1, 0, 16'h07FC);
    cfgModel = 16'h07FC;
    endReq();
    doReq(32'h0C00_0000, 1, 0, model(cfgModel, 32'h0C00_0000, 1, 0),
          "R10 after write", 0, 0, 0, '0);
    endReq();

    // R10: write while counting down keeps the old cost
    oldCfg = cfgModel;
    doReq(32'h0D00_0000, 1, 0, model(oldCfg, 32'h0D00_0000, 1, 0),
          "R10 mid-access write", 0, 0, 1, 16'h0000);
    cfgModel = 16'h0000;
    endReq();
    doReq(32'h0D00_0000, 1, 0, model(cfgModel, 32'h0D00_0000, 1, 0),
          "R10 new word used", 0, 0, 0, '0);
    endReq();

    // R8: idle with no request: no stall, no ready
    repeat (3) begin
      @(negedge clk);
      chk(!busStall && !reqReady, "R8 idle quiet", int'({busStall, reqReady}), 0);
    end

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R8 all requests completed", expQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule